// File: doc/BRIEF.md
# Two-Digit Hex Key Display Driver

This block accepts a stream of already validated 4-bit hexadecimal key codes and shows the two most recently accepted codes on a dual seven-segment display. The newest code always sits in the right digit. When a code arrives, the code that was in the right digit moves to the left digit.

The two digits share one set of seven segment lines, and each digit has its own enable line. A refresh divider switches the active digit every `HALF_PERIOD` clock cycles. With a 12 MHz clock and the default of 100000, a full refresh cycle takes 200000 clocks, which is 60 Hz. The segment lines always carry the pattern of whichever digit is enabled at that moment. Segments and enables are both active-low, which suits a common-anode display driven through high-side PNP switches. A digit that has not yet received a code stays dark.

The key input is a valid/ready stream. The block never applies back-pressure: `key_ready` is high in every cycle. A code is taken on any rising clock edge where `key_valid` is high, including edges that follow one another directly.

Top module: `hexpair_display`

## Requirements
- R1: `key_ready` is 1 in every cycle. Every clock edge with `key_valid` high accepts `key_code`, including back-to-back edges.
- R2: On an accepted code, the right digit takes the new code and the left digit takes the value the right digit held before that edge.
- R3: A loaded digit shows its value on `seg_n[6:0]`. The bit order is {g,f,e,d,c,b,a}, and a segment is lit when its bit is 0. The lit patterns (active-high, in hex) for 0 to F are: 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. Values B and D use the lowercase forms b and d.
- R4: A digit that holds no code yet is blank, so `seg_n` is 7'h7F while that digit is enabled.
- R5: The active digit changes exactly once every `HALF_PERIOD` clock cycles. After reset the right digit is active first.
- R6: Exactly one bit of `dig_n` is 0 in every cycle, including during reset. Bit 0 enables the right digit and bit 1 enables the left digit.
- R7: `seg_n` shows the pattern of the digit whose enable is currently low.
- R8: Reset clears both stored digits to the empty state and restarts the refresh timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | Key code is present on this cycle |
| key_code | input | 4 | Hex value of the key |
| key_ready | output | 1 | Always 1: the block accepts every code |
| seg_n | output | 7 | Shared segments {g,f,e,d,c,b,a}, active-low |
| dig_n | output | 2 | Digit enables, active-low; bit 0 right, bit 1 left |

## Verification
A wrong shift in the store shows at the ports on the first cycle the affected digit is enabled, which is at most `HALF_PERIOD` cycles after the faulty edge. A wrong divider count shifts every later enable change, so the error shows at the first expected switch. A wrong decode table or wrong segment multiplexing shows up on the next cycle that displays the affected value or digit. The bench therefore uses a short refresh period and compares both outputs on every clock, so each of these faults appears within a few cycles.

// File: rtl/hexpair_pkg.sv
package hexpair_pkg;
  typedef logic [3:0] nibble_t;
  typedef struct packed {
    logic    loaded;
    nibble_t value;
  } digit_t;
  localparam logic [6:0] SEG_OFF_N = 7'h7F;
endpackage

// File: rtl/hexpair_store.sv
module hexpair_store
  import hexpair_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  nibble_t code,
  output digit_t  right_d,
  output digit_t  left_d
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      right_d <= '0;
      left_d  <= '0;
    end else if (push) begin
      left_d  <= right_d;
      right_d <= '{loaded: 1'b1, value: code};
    end
  end

  // R2
  new_code_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (right_d.loaded && right_d.value == $past(code)));
  // R2
  shift_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (left_d == $past(right_d)));
endmodule

// File: rtl/hexpair_refresh.sv
module hexpair_refresh #(
  parameter int unsigned HALF_PERIOD = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic sel_left
);
  localparam int unsigned CW = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sel_left <= 1'b0;
    end else if (cnt == LAST) begin
      cnt      <= '0;
      sel_left <= ~sel_left;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5
  switch_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LAST) |=> (sel_left != $past(sel_left)));
  // R5
  hold_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != LAST) |=> $stable(sel_left));
endmodule

// File: rtl/hexpair_seg7.sv
module hexpair_seg7
  import hexpair_pkg::*;
(
  input  digit_t     dig,
  output logic [6:0] seg_n
);
  logic [6:0] lit;
  always_comb begin
    unique case (dig.value)
      4'h0: lit = 7'h3F;  4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;  4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;  4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;  4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;  4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;  4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;  4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;  default: lit = 7'h71;
    endcase
    seg_n = dig.loaded ? ~lit : SEG_OFF_N;
  end
endmodule

// File: rtl/hexpair_display.sv
module hexpair_display
  import hexpair_pkg::*;
#(
  parameter int unsigned HALF_PERIOD = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_valid,
  input  logic [3:0] key_code,
  output logic       key_ready,
  output logic [6:0] seg_n,
  output logic [1:0] dig_n
);
  digit_t     right_d, left_d, shown;
  logic       sel_left;

  assign key_ready = 1'b1;

  hexpair_store u_store (
    .clk(clk), .rst_n(rst_n), .push(key_valid && key_ready),
    .code(key_code), .right_d(right_d), .left_d(left_d)
  );

  hexpair_refresh #(.HALF_PERIOD(HALF_PERIOD)) u_refresh (
    .clk(clk), .rst_n(rst_n), .sel_left(sel_left)
  );

  assign shown = sel_left ? left_d : right_d;
  assign dig_n = sel_left ? 2'b01 : 2'b10;

  hexpair_seg7 u_seg7 (.dig(shown), .seg_n(seg_n));

  // R6
  one_digit_on_chk: assert property (@(posedge clk)
    $countones(~dig_n) == 1);
  // R4
  empty_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!dig_n[0] && !right_d.loaded) || (!dig_n[1] && !left_d.loaded))
      |-> (seg_n == SEG_OFF_N));
  // R1
  always_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_ready);
endmodule

// File: tb/test_hexpair_display.sv
module test_hexpair_display;
  localparam int HP = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_valid = 1'b0;
  logic [3:0] key_code = 4'h0;
  logic       key_ready;
  logic [6:0] seg_n;
  logic [1:0] dig_n;

  int vectors = 0;
  int errors  = 0;

  always #5 clk = ~clk;

  hexpair_display #(.HALF_PERIOD(HP)) i_hexpair_display (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
    .key_ready(key_ready), .seg_n(seg_n), .dig_n(dig_n)
  );

  // behavioural reference: queue of recent codes, cycle counter, side flag
  int   hist[$];
  int   ref_cnt = 0;
  bit   ref_left = 0;
  int   toggles = 0;

  function automatic logic [6:0] pattern(int v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    if (v < 0) return 7'h7F;
    return ~t[v];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      ref_cnt  = 0;
      ref_left = 0;
    end else begin
      ref_cnt++;
      if (ref_cnt == HP) begin
        ref_cnt = 0;
        ref_left = !ref_left;
        toggles++;
      end
      if (key_valid) begin
        hist.push_front(int'(key_code));
        if (hist.size() > 2) void'(hist.pop_back());
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison (R3, R4, R6, R7)
  always @(negedge clk) begin
    int shown;
    shown = ref_left ? ((hist.size() > 1) ? hist[1] : -1)
                     : ((hist.size() > 0) ? hist[0] : -1);
    check("R6 dig_n", 32'(dig_n), ref_left ? 32'h1 : 32'h2);
    check("R7/R3/R4 seg_n", 32'(seg_n), 32'(pattern(shown)));
    check("R1 key_ready", 32'(key_ready), 32'h1);
  end

  task automatic push(int v);
    key_valid <= 1'b1; key_code <= 4'(v);
    @(negedge clk);
    key_valid <= 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state: right digit enabled, blank
    check("R8 reset seg", 32'(seg_n), 32'h7F);
    check("R8 reset dig", 32'(dig_n), 32'h2);
    rst_n <= 1'b1;
    repeat (12) @(negedge clk);
    // R5: after 12 cycles with HP=5, two switches happened
    check("R5 toggles", 32'(toggles), 32'd2);
    // R2 single key, then gap
    push(4'hA);
    repeat (11) @(negedge clk);
    // R1 back-to-back, all 16 values (R3)
    for (int v = 0; v < 16; v++) push(v);
    repeat (11) @(negedge clk);
    // sparse keys
    for (int v = 15; v >= 0; v -= 3) begin
      push(v);
      repeat (v % 4 + 3) @(negedge clk);
    end
    // R8 mid-run reset clears digits
    rst_n <= 1'b0;
    @(negedge clk);
    check("R8 cleared seg", 32'(seg_n), 32'h7F);
    rst_n <= 1'b1;
    repeat (11) @(negedge clk);
    push(4'hD); push(4'hB);
    repeat (12) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule